// File: doc/BRIEF.md
# GPIO bank with per-pin interrupt detection

The block is one bank of general-purpose I/O pins behind a small 32-bit register bus. Software picks each pin's direction, enables its input path, sets the level it drives, and gates which pins the data register may touch. Pad inputs pass through a two-flop synchroniser and then feed the data read path and a per-pin event detector.

Each pin's event detector is set up by three independent bits: level or edge sensing, a both-edges override, and a polarity bit. Edge events are held in a status bit until software clears it with a write-one-to-clear register. Level events are not held: their status follows the pin. The status is ANDed with a per-pin enable into a masked status, and a single registered, active-high interrupt output reports whether any masked bit is set.

Bus access uses one request strobe with a write flag. A write takes effect at the clock edge that samples it. Read data appears on `rdata_o` on the cycle after the read request and stays there until the next read.

Top module: `gpio_bank`

## Requirements
- R1: After reset every writable register is 0, `pad_o`, `pad_oe_o` and `irq_o` are 0, and every readable offset returns 0.
- R2: `pad_oe_o[i]` equals the direction bit of pin i (offset 0x08, 1 = drive). `pad_o[i]` equals the stored output data bit of pin i (offset 0x00).
- R3: The data-access register (offset 0x04) gates the data register. A write to offset 0x00 changes only the bits whose access bit is 1, and a read returns 0 in every bit whose access bit is 0.
- R4: A read of offset 0x00 returns, for an enabled pin, the stored output bit if it is an output. If it is an input, the read returns the synchronised pad value when its input-enable bit (offset 0x28) is 1, and 0 when that bit is 0. A pad change is visible two clock edges after it is sampled.
- R5: A pin with its sense bit (offset 0x0C) at 0 and its both-edges bit (offset 0x10) at 0 latches its raw status bit (offset 0x1C) on a rising edge when its polarity bit (offset 0x14) is 1, and on a falling edge when that bit is 0.
- R6: When the both-edges bit is 1 in edge mode, rising and falling edges both latch the raw status bit, whatever the polarity bit holds.
- R7: With the sense bit at 1, the raw status bit follows the synchronised, input-enabled pin level: true when the level is high for polarity 1, and when it is low for polarity 0. It is not latched, and a clear write has no lasting effect on it.
- R8: The masked status (offset 0x20) equals raw status AND the interrupt-enable bits (offset 0x18). `irq_o` is the OR of the masked status, one clock edge later.
- R9: Writing 1 to a bit of offset 0x24 clears that pin's latched edge status. Writing 0 leaves it unchanged, and a read of 0x24 returns 0.
- R10: If an edge is detected on a pin in the same cycle as a clear write to that pin, the status bit stays set.
- R11: Word offsets are decoded from address bits 7:2, and the low two address bits are ignored. Offsets above 0x28 read 0 and writes to them do nothing. Bits 31:16 of every read are 0.
- R12: Writes to offsets 0x1C and 0x20 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW (8) | Byte address within the bank |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Read data, valid the cycle after a read |
| pad_i | input | NPIN (16) | Pad input levels |
| pad_o | output | NPIN (16) | Pad output levels |
| pad_oe_o | output | NPIN (16) | Pad output enables |
| irq_o | output | 1 | Bank interrupt, active high |

## Verification
The bench builds the block with its defaults: 16 pins, a 32-bit data bus and an 8-bit address. With these values a full 16-bit pin vector fits in each register and leaves 16 upper bits that must read zero. The 8-bit address also reaches offsets past the last register, up to 0x80 and beyond, so the decode is tested against aliasing. A behavioural reference model runs beside the design and checks its pins, interrupt and read data on every clock. Each detection mode and the clear-versus-edge collision are driven at cycle-exact times.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // word index = addr[5:2]; order fixed by software
  typedef enum logic [3:0] {
    IDX_DATA = 4'd0,
    IDX_ACC  = 4'd1,
    IDX_DIR  = 4'd2,
    IDX_LVL  = 4'd3,
    IDX_BOTH = 4'd4,
    IDX_POL  = 4'd5,
    IDX_IEN  = 4'd6,
    IDX_RAW  = 4'd7,
    IDX_MSK  = 4'd8,
    IDX_CLR  = 4'd9,
    IDX_INEN = 4'd10
  } reg_idx_e;

  localparam int unsigned IDX_W = 4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_irq_det.sv
module gpio_irq_det #(
  parameter int unsigned NPIN = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] pin_i,
  input  logic [NPIN-1:0] lvl_i,
  input  logic [NPIN-1:0] both_i,
  input  logic [NPIN-1:0] pol_i,
  input  logic [NPIN-1:0] clr_i,
  output logic [NPIN-1:0] hit_o,
  output logic [NPIN-1:0] raw_o
);
  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic prev_q, latch_q, rise, fall;

    assign rise = pin_i[g] & ~prev_q;
    assign fall = ~pin_i[g] & prev_q;

    assign hit_o[g] = ~lvl_i[g] &
                      (both_i[g] ? (rise | fall) : (pol_i[g] ? rise : fall));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q  <= 1'b0;
        latch_q <= 1'b0;
      end else begin
        prev_q <= pin_i[g];
        // new edge beats a same-cycle clear
        if (hit_o[g])      latch_q <= 1'b1;
        else if (clr_i[g]) latch_q <= 1'b0;
      end
    end

    assign raw_o[g] = lvl_i[g] ? ~(pin_i[g] ^ pol_i[g]) : latch_q;
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NPIN = 16,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NPIN-1:0] pin_i,
  input  logic [NPIN-1:0] raw_i,
  input  logic [NPIN-1:0] msk_i,
  output logic [DW-1:0]   rdata_o,
  output logic [NPIN-1:0] data_o,
  output logic [NPIN-1:0] acc_o,
  output logic [NPIN-1:0] dir_o,
  output logic [NPIN-1:0] lvl_o,
  output logic [NPIN-1:0] both_o,
  output logic [NPIN-1:0] pol_o,
  output logic [NPIN-1:0] ien_o,
  output logic [NPIN-1:0] inen_o,
  output logic [NPIN-1:0] clr_o
);
  localparam int unsigned IDX_LSB = 2;
  localparam int unsigned IDX_MSB = IDX_LSB + IDX_W - 1;

  reg_idx_e        widx;
  logic            in_map, wr, rd;
  logic [NPIN-1:0] wd, rd_val;
  logic [DW-1:0]   rdata_q;
  logic [NPIN-1:0] data_q, acc_q, dir_q, lvl_q, both_q, pol_q, ien_q, inen_q;
  logic            unused_bits;

  assign widx   = reg_idx_e'(addr_i[IDX_MSB:IDX_LSB]);
  assign in_map = (addr_i[AW-1:IDX_MSB+1] == '0) &&
                  (addr_i[IDX_MSB:IDX_LSB] <= IDX_W'(IDX_INEN));
  assign wr     = req_i & we_i & in_map;
  assign rd     = req_i & ~we_i & in_map;
  assign wd     = wdata_i[NPIN-1:0];
  assign unused_bits = ^{wdata_i[DW-1:NPIN], addr_i[IDX_LSB-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      acc_q  <= '0;
      dir_q  <= '0;
      lvl_q  <= '0;
      both_q <= '0;
      pol_q  <= '0;
      ien_q  <= '0;
      inen_q <= '0;
    end else if (wr) begin
      case (widx)
        IDX_DATA: data_q <= (data_q & ~acc_q) | (wd & acc_q);
        IDX_ACC:  acc_q  <= wd;
        IDX_DIR:  dir_q  <= wd;
        IDX_LVL:  lvl_q  <= wd;
        IDX_BOTH: both_q <= wd;
        IDX_POL:  pol_q  <= wd;
        IDX_IEN:  ien_q  <= wd;
        IDX_INEN: inen_q <= wd;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_val = '0;
    case (widx)
      IDX_DATA: rd_val = acc_q & ((dir_q & data_q) | (~dir_q & pin_i));
      IDX_ACC:  rd_val = acc_q;
      IDX_DIR:  rd_val = dir_q;
      IDX_LVL:  rd_val = lvl_q;
      IDX_BOTH: rd_val = both_q;
      IDX_POL:  rd_val = pol_q;
      IDX_IEN:  rd_val = ien_q;
      IDX_RAW:  rd_val = raw_i;
      IDX_MSK:  rd_val = msk_i;
      IDX_INEN: rd_val = inen_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd ? DW'(rd_val) : '0;
  end

  assign rdata_o = rdata_q;
  assign clr_o   = (wr && widx == IDX_CLR) ? wd : '0;
  assign data_o  = data_q;
  assign acc_o   = acc_q;
  assign dir_o   = dir_q;
  assign lvl_o   = lvl_q;
  assign both_o  = both_q;
  assign pol_o   = pol_q;
  assign ien_o   = ien_q;
  assign inen_o  = inen_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int unsigned NPIN = 16,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [NPIN-1:0] pad_i,
  output logic [NPIN-1:0] pad_o,
  output logic [NPIN-1:0] pad_oe_o,
  output logic            irq_o
);
  logic [NPIN-1:0] pad_sync, pin_in;
  logic [NPIN-1:0] data_q, acc_en, dir_q, lvl_sel, both_sel, pol_sel;
  logic [NPIN-1:0] irq_en, inen_q, clr_vec, edge_hit, raw_st, msk_st;
  logic            irq_q;

  gpio_sync #(.W(NPIN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (pad_sync)
  );

  assign pin_in = pad_sync & inen_q;

  gpio_regs #(.NPIN(NPIN), .DW(DW), .AW(AW)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .pin_i  (pin_in),
    .raw_i  (raw_st),
    .msk_i  (msk_st),
    .rdata_o(rdata_o),
    .data_o (data_q),
    .acc_o  (acc_en),
    .dir_o  (dir_q),
    .lvl_o  (lvl_sel),
    .both_o (both_sel),
    .pol_o  (pol_sel),
    .ien_o  (irq_en),
    .inen_o (inen_q),
    .clr_o  (clr_vec)
  );

  gpio_irq_det #(.NPIN(NPIN)) u_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_in),
    .lvl_i (lvl_sel),
    .both_i(both_sel),
    .pol_i (pol_sel),
    .clr_i (clr_vec),
    .hit_o (edge_hit),
    .raw_o (raw_st)
  );

  assign msk_st = raw_st & irq_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |msk_st;
  end

  assign irq_o    = irq_q;
  assign pad_o    = data_q;
  assign pad_oe_o = dir_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_pkg::*;
#(
  parameter int unsigned NPIN = 16,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic            we_i,
  input logic [AW-1:0]   addr_i,
  input logic [DW-1:0]   rdata_o,
  input logic [NPIN-1:0] pad_o,
  input logic            irq_o,
  input logic [NPIN-1:0] hit_i,
  input logic [NPIN-1:0] lvl_i,
  input logic [NPIN-1:0] raw_i,
  input logic [NPIN-1:0] ien_i,
  input logic [NPIN-1:0] acc_i
);
  assert_irq_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(raw_i & ien_i)));

  assert_edge_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_i) |=> (((raw_i | lvl_i) & $past(hit_i)) == $past(hit_i)));

  assert_clr_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == AW'({IDX_CLR, 2'b00})) |=> (rdata_o == '0));

  assert_upper_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o >> NPIN) == '0);

  assert_data_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == AW'({IDX_DATA, 2'b00})) |=>
      (((pad_o ^ $past(pad_o)) & ~$past(acc_i)) == '0));
endmodule

bind gpio_bank gpio_bank_chk #(.NPIN(NPIN), .DW(DW), .AW(AW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .we_i   (we_i),
  .addr_i (addr_i),
  .rdata_o(rdata_o),
  .pad_o  (pad_o),
  .irq_o  (irq_o),
  .hit_i  (edge_hit),
  .lvl_i  (lvl_sel),
  .raw_i  (raw_st),
  .ien_i  (irq_en),
  .acc_i  (acc_en)
);

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
  localparam int NPIN = 16;
  localparam int DW   = 32;
  localparam int AW   = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req = 1'b0, we = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [DW-1:0]   wdata = '0;
  logic [DW-1:0]   rdata;
  logic [NPIN-1:0] pad = '0, pad_o, pad_oe;
  logic            irq;

  int    n_cmp = 0, n_bad = 0;
  string phase = "R1";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank #(.NPIN(NPIN), .DW(DW), .AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad), .pad_o(pad_o),
    .pad_oe_o(pad_oe), .irq_o(irq)
  );

  // behavioural reference model
  logic [NPIN-1:0] m_data, m_acc, m_dir, m_lvl, m_both, m_pol, m_ien, m_inen;
  logic [NPIN-1:0] m_s1, m_s2, m_prev, m_lat, t_pin, t_raw, t_hit;
  logic [DW-1:0]   m_rd;
  logic            m_irq;

  function automatic logic [DW-1:0] model_read(input int idx);
    logic [NPIN-1:0] v;
    case (idx)
      0: v = m_acc & ((m_dir & m_data) | (~m_dir & t_pin));
      1: v = m_acc;   2: v = m_dir;  3: v = m_lvl;  4: v = m_both;
      5: v = m_pol;   6: v = m_ien;  7: v = t_raw;  8: v = t_raw & m_ien;
      10: v = m_inen;
      default: v = '0;
    endcase
    return DW'(v);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_data, m_acc, m_dir, m_lvl, m_both, m_pol, m_ien, m_inen} = '0;
      {m_s1, m_s2, m_prev, m_lat} = '0;
      m_rd = '0; m_irq = 1'b0;
    end else begin
      int idx;
      idx = (addr >> 2);
      t_pin = m_s2 & m_inen;
      for (int i = 0; i < NPIN; i++) begin
        bit r, f;
        r = t_pin[i] && !m_prev[i];
        f = !t_pin[i] && m_prev[i];
        t_raw[i] = m_lvl[i] ? (m_pol[i] ? t_pin[i] : !t_pin[i]) : m_lat[i];
        t_hit[i] = !m_lvl[i] && (m_both[i] ? (r || f) : (m_pol[i] ? r : f));
      end
      m_irq = |(t_raw & m_ien);
      if (req && !we) m_rd = model_read(idx);
      for (int i = 0; i < NPIN; i++) begin
        if (t_hit[i]) m_lat[i] = 1'b1;
        else if (req && we && idx == 9 && wdata[i]) m_lat[i] = 1'b0;
      end
      m_prev = t_pin; m_s2 = m_s1; m_s1 = pad;
      if (req && we) begin
        case (idx)
          0: for (int i = 0; i < NPIN; i++) if (m_acc[i]) m_data[i] = wdata[i];
          1: m_acc  = wdata[NPIN-1:0];
          2: m_dir  = wdata[NPIN-1:0];
          3: m_lvl  = wdata[NPIN-1:0];
          4: m_both = wdata[NPIN-1:0];
          5: m_pol  = wdata[NPIN-1:0];
          6: m_ien  = wdata[NPIN-1:0];
          10: m_inen = wdata[NPIN-1:0];
          default: ;
        endcase
      end
    end
  end

  task automatic cmp(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp("rdata_o", rdata, m_rd);
      cmp("irq_o", DW'(irq), DW'(m_irq));
      cmp("pad_o", DW'(pad_o), DW'(m_data));       // R2
      cmp("pad_oe_o", DW'(pad_oe), DW'(m_dir));    // R2
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd_all;
    for (int a = 0; a <= 8'h28; a += 4) rd(AW'(a));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1; n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1'b1;
    // R1: reset state at the ports
    @(negedge clk);
    phase = "R1";
    cmp("rst rdata_o", rdata, '0);
    cmp("rst irq_o", DW'(irq), '0);
    cmp("rst pad_oe_o", DW'(pad_oe), '0);
    rd_all();

    // R11: unmapped offsets, aliasing, low address bits
    phase = "R11";
    wr(8'h2C, 32'hFFFF_FFFF);
    wr(8'h88, 32'hFFFF_FFFF);
    rd(8'h2C); rd(8'h40); rd(8'h84); rd(8'h88);
    wr(8'h06, 32'hFFFF_0003);       // acc via low-bit alias
    rd(8'h04);

    // R2: direction and output data
    phase = "R2";
    wr(8'h04, 32'h0000_FFFF);
    wr(8'h08, 32'h0000_00FF);
    wr(8'h00, 32'hFFFF_A5A5);
    idle(2);

    // R3: access gating of data writes and reads
    phase = "R3";
    wr(8'h04, 32'h0000_0F0F);
    wr(8'h00, 32'h0000_FFFF);
    rd(8'h00);
    wr(8'h00, 32'h0000_0000);
    rd(8'h00);

    // R4: input path through synchroniser and input enable
    phase = "R4";
    wr(8'h04, 32'h0000_FFFF);
    wr(8'h28, 32'h0000_F000);
    pad = 16'h3C3C;
    rd(8'h00); rd(8'h00); rd(8'h00);
    wr(8'h08, 32'h0);
    wr(8'h28, 32'h0000_FF00);
    rd(8'h00);
    pad = 16'h0000; idle(3);

    // R5: single edge detection, rising on pin0, falling on pin1
    phase = "R5";
    wr(8'h28, 32'h0000_FFFF);
    wr(8'h14, 32'h0000_0001);
    wr(8'h18, 32'h0000_FFFF);
    pad = 16'h0002; idle(4);
    rd(8'h1C); rd(8'h20);
    pad = 16'h0001; idle(4);
    rd(8'h1C);
    pad = 16'h0000; idle(4);
    rd(8'h1C);

    // R9: write-one-to-clear, zero write, read of clear offset
    phase = "R9";
    wr(8'h24, 32'h0000_0000);
    rd(8'h1C);
    wr(8'h24, 32'h0000_0001);
    rd(8'h1C); rd(8'h24);
    wr(8'h24, 32'h0000_FFFF);
    idle(2);

    // R6: both edges, polarity ignored
    phase = "R6";
    wr(8'h10, 32'h0000_0004);
    wr(8'h14, 32'h0000_0000);
    pad = 16'h0004; idle(4); rd(8'h1C);
    wr(8'h24, 32'h0000_0004); rd(8'h1C);
    pad = 16'h0000; idle(4); rd(8'h1C);
    wr(8'h24, 32'h0000_FFFF);

    // R10: edge in the same cycle as a clear
    phase = "R10";
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h0000_0001);
    idle(2);
    @(negedge clk); pad = 16'h0001;
    @(negedge clk);
    wr(8'h24, 32'h0000_0001);
    rd(8'h1C); rd(8'h20);
    pad = 16'h0000;
    wr(8'h24, 32'h0000_FFFF);
    idle(3);

    // R7: level sensing, high on pin3, low on pin4
    phase = "R7";
    wr(8'h14, 32'h0000_0008);
    wr(8'h0C, 32'h0000_0018);
    idle(3); rd(8'h1C);
    pad = 16'h0018; idle(3); rd(8'h1C);
    wr(8'h24, 32'h0000_0018); rd(8'h1C);
    pad = 16'h0000; idle(3); rd(8'h1C);

    // R8: masking and interrupt output
    phase = "R8";
    wr(8'h18, 32'h0000_0000); idle(2); rd(8'h20);
    wr(8'h18, 32'h0000_0010); idle(2); rd(8'h20);
    wr(8'h0C, 32'h0); wr(8'h24, 32'h0000_FFFF); idle(2);

    // R12: status registers are not writable
    phase = "R12";
    wr(8'h18, 32'h0000_FFFF);
    wr(8'h1C, 32'h0000_FFFF);
    wr(8'h20, 32'h0000_FFFF);
    rd(8'h1C); rd(8'h20); idle(2);

    phase = "R1";
    rd_all();
    idle(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule